// File: doc/BRIEF.md
# Bus Function Configuration Register File

This block holds the 256-byte configuration image of one function on a shared peripheral bus. A configuration agent reads and writes it one, two or four bytes at a time. Every byte has its own write-enable mask, so read-only identity fields keep their values while software-owned fields take the written data. The masks for the base address registers come from the size and type of each address region. Writing all ones to a base register and reading it back therefore shows the region's size, and the type bits stay fixed.

A select input tells the block whether the function exists. When the select is low, writes are dropped and reads return all ones of the requested width. When a write changes the address-decode state, the block raises a one-cycle remap pulse so that address decoders outside can rebuild their windows. The decode state is any byte of the base register area or the I/O or memory enable bit of the command byte. An asynchronous reset reloads the whole image: the identity values, the header type, the base registers holding only their type bits, and zeros everywhere else.

Top module: `fn_cfg_regfile`

## Requirements
- R1: Reset loads the identity dword at 0x00, the class dword at 0x08 and the header type at 0x0E from parameters. Each implemented base register's low byte gets its 4-bit type code (bit 0 = I/O space, bits 2:1 = 2'b10 for 64-bit memory, bit 3 = prefetchable). The command byte 0x04, cache line size 0x0C, interrupt line 0x3C and every other byte become 0.
- R2: A write updates each addressed byte as (old AND NOT mask) OR (new AND mask). Byte k of the write data (bits 8k+7:8k) goes to address+k. The number of bytes is set by len: 1 gives one byte, 2 gives two, any other value gives four. Bytes past offset 0xFF are dropped.
- R3: In the 64-byte header, only these fields are writable: byte 0x0C, byte 0x3C, and bits 2:0 of byte 0x04 (I/O enable, memory enable, bus master). All other header bytes outside the base and expansion-ROM registers are read-only.
- R4: Bytes 0x40 to 0xFF are fully writable.
- R5: Base register n sits at 0x10+4n (n = 0..5). After all ones are written, it reads back the low 32 bits of NOT(size-1). The type field stays at its code: bits 1:0 for an I/O region, bits 3:0 for a memory region. An unimplemented register reads 0.
- R6: A 64-bit memory region takes its own register and the next one. The next register holds bits 63:32 of NOT(size-1).
- R7: The expansion-ROM register is at 0x30, or at 0x38 when header type bits 6:0 equal 1. Bit 7 is ignored for this choice. Its writable bits are NOT(size-1) plus the enable bit 0.
- R8: A read loads rdata in the cycle after rd is sampled, little-endian. Byte lanes beyond len or past 0xFF read 0. rdata holds its value while rd is low.
- R9: With sel low, a read returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for len 1, 2 or 4.
- R10: With sel low, a write changes no byte of the image.
- R11: remap is high for exactly the cycle after a selected write that changes any byte in 0x10 to 0x27, or that flips bit 0 or bit 1 of byte 0x04. Other writes do not raise it: writes to other bytes, writes that leave these bytes unchanged, and writes to the bus-master bit alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Function present; low makes accesses miss |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the access |
| len | input | 3 | Access length in bytes (1, 2 or 4) |
| wdata | input | 32 | Write data, little-endian lanes |
| rdata | output | 32 | Registered read data |
| remap | output | 1 | One-cycle pulse when decode state changed |

## Verification
The bench writes all ones to every base register and to the expansion-ROM register, and checks each read-back against sizes computed in the bench. A wrong mask would expose type bits or low address bits, or would leave the upper half of the 64-bit region read-only. A second instance with a bridge header checks that the ROM register moves to 0x38 and that 0x30 becomes inert; a design that kept it fixed would size the wrong dword. The bench also covers the cases that separate a real change from a write attempt. These are a write into the base area that the mask fully blocks, a repeated identical write, and a bus-master-only write, none of which may pulse remap. Accesses that run past 0xFF must neither wrap to 0x00 nor corrupt it.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int CFG_BYTES   = 256;
  localparam int HDR_BYTES   = 64;
  localparam int OFS_ID      = 0;
  localparam int OFS_CMD     = 4;
  localparam int OFS_CLASS   = 8;
  localparam int OFS_CLS     = 12;
  localparam int OFS_HDRT    = 14;
  localparam int OFS_BAR0    = 16;
  localparam int OFS_ROM_STD = 48;
  localparam int OFS_ROM_BRG = 56;
  localparam int OFS_INTL    = 60;
  localparam logic [7:0] CMD_WMASK = 8'h07;

  typedef logic [CFG_BYTES-1:0][7:0] cfg_img_t;

  function automatic int lane_count(input logic [2:0] len);
    case (len)
      3'd1:    return 1;
      3'd2:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic is_mem64(input logic [3:0] ty);
    return (!ty[0]) && (ty[2:1] == 2'b10);
  endfunction

  function automatic logic [63:0] size_mask(input logic [5:0] lg);
    return ~((64'd1 << lg) - 64'd1);
  endfunction
endpackage

// File: rtl/cfgs_mask.sv
module cfgs_mask
  import cfgs_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6,
  parameter logic [NUM_BARS:0][5:0] BAR_LOG2 = '0,
  parameter logic [NUM_BARS:0][3:0] BAR_TYPE = '0,
  parameter logic [31:0] ID_DW    = 32'h0,
  parameter logic [31:0] CLASS_DW = 32'h0,
  parameter logic [7:0]  HDR_TYPE = 8'h00
) (
  output cfg_img_t wmask,
  output cfg_img_t rst_img
);
  localparam int ROM_OFS = ((HDR_TYPE & 8'h7F) == 8'h01) ? OFS_ROM_BRG : OFS_ROM_STD;

  function automatic logic [7:0] mask_at(input int a);
    logic [7:0]  r;
    logic [63:0] m;
    int base;
    r = 8'h00;
    if (a >= HDR_BYTES)                  r = 8'hFF;
    else if (a == OFS_CLS || a == OFS_INTL) r = 8'hFF;
    else if (a == OFS_CMD)               r = CMD_WMASK;
    for (int i = 0; i < int'(NUM_BARS); i++) begin
      base = OFS_BAR0 + 4 * i;
      if (BAR_LOG2[i] != 6'd0) begin
        m = size_mask(BAR_LOG2[i]);
        if (a >= base && a < base + 4) begin
          r = m[8*(a-base) +: 8];
          if (a == base) r = r & (BAR_TYPE[i][0] ? 8'hFC : 8'hF0);
        end
        if (is_mem64(BAR_TYPE[i]) && a >= base + 4 && a < base + 8)
          r = m[32 + 8*(a-base-4) +: 8];
      end
    end
    if (BAR_LOG2[NUM_BARS] != 6'd0 && a >= ROM_OFS && a < ROM_OFS + 4) begin
      m = size_mask(BAR_LOG2[NUM_BARS]);
      r = m[8*(a-ROM_OFS) +: 8];
      if (a == ROM_OFS) r = r | 8'h01;
    end
    return r;
  endfunction

  function automatic logic [7:0] rst_at(input int a);
    logic [7:0] r;
    r = 8'h00;
    if (a >= OFS_ID && a < OFS_ID + 4)       r = ID_DW[8*(a-OFS_ID) +: 8];
    if (a >= OFS_CLASS && a < OFS_CLASS + 4) r = CLASS_DW[8*(a-OFS_CLASS) +: 8];
    if (a == OFS_HDRT)                       r = HDR_TYPE;
    for (int i = 0; i < int'(NUM_BARS); i++)
      if (BAR_LOG2[i] != 6'd0 && a == OFS_BAR0 + 4 * i) r = {4'h0, BAR_TYPE[i]};
    return r;
  endfunction

  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
    assign wmask[g]   = mask_at(g);
    assign rst_img[g] = rst_at(g);
  end
endmodule

// File: rtl/cfgs_merge.sv
module cfgs_merge
  import cfgs_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6
) (
  input  cfg_img_t    cur,
  input  cfg_img_t    wmask,
  input  logic        en,
  input  logic [7:0]  addr,
  input  logic [2:0]  len,
  input  logic [31:0] wdata,
  output cfg_img_t    nxt,
  output logic        bar_chg
);
  localparam int BAR_LO = OFS_BAR0;
  localparam int BAR_HI = OFS_BAR0 + 4 * int'(NUM_BARS) - 1;

  always_comb begin
    logic [8:0] idx;
    logic [7:0] b;
    nxt = cur;
    for (int k = 0; k < 4; k++) begin
      idx = {1'b0, addr} + 9'(k);
      b   = idx[7:0];
      if (en && k < lane_count(len) && !idx[8])
        nxt[b] = (cur[b] & ~wmask[b]) | (wdata[8*k +: 8] & wmask[b]);
    end
  end

  always_comb begin
    bar_chg = (cur[OFS_CMD][1:0] != nxt[OFS_CMD][1:0]);
    for (int a = BAR_LO; a <= BAR_HI; a++)
      bar_chg = bar_chg | (cur[a] != nxt[a]);
  end
endmodule

// File: rtl/cfgs_rmux.sv
module cfgs_rmux
  import cfgs_pkg::*;
(
  input  cfg_img_t    img,
  input  logic        sel,
  input  logic [7:0]  addr,
  input  logic [2:0]  len,
  output logic [31:0] dout
);
  always_comb begin
    logic [8:0] idx;
    dout = '0;
    for (int k = 0; k < 4; k++) begin
      idx = {1'b0, addr} + 9'(k);
      if (k < lane_count(len)) begin
        if (!sel)         dout[8*k +: 8] = 8'hFF;
        else if (!idx[8]) dout[8*k +: 8] = img[idx[7:0]];
      end
    end
  end
endmodule

// File: rtl/fn_cfg_regfile.sv
module fn_cfg_regfile
  import cfgs_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6,
  parameter logic [NUM_BARS:0][5:0] BAR_LOG2 =
    {6'd14, 6'd8, 6'd0, 6'd0, 6'd33, 6'd12, 6'd5},
  parameter logic [NUM_BARS:0][3:0] BAR_TYPE =
    {4'h0, 4'h8, 4'h0, 4'h0, 4'hC, 4'h0, 4'h1},
  parameter logic [31:0] ID_DW    = 32'h5A17_1BE5,
  parameter logic [31:0] CLASS_DW = 32'h0200_0001,
  parameter logic [7:0]  HDR_TYPE = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic        rd,
  input  logic [7:0]  addr,
  input  logic [2:0]  len,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        remap
);
  cfg_img_t    cfg_q;
  cfg_img_t    wmask;
  cfg_img_t    rst_img;
  cfg_img_t    cfg_nxt;
  logic        wr_fire;
  logic        bar_chg;
  logic [31:0] rd_val;

  assign wr_fire = wr && sel;

  cfgs_mask #(
    .NUM_BARS(NUM_BARS), .BAR_LOG2(BAR_LOG2), .BAR_TYPE(BAR_TYPE),
    .ID_DW(ID_DW), .CLASS_DW(CLASS_DW), .HDR_TYPE(HDR_TYPE)
  ) u_mask (
    .wmask  (wmask),
    .rst_img(rst_img)
  );

  cfgs_merge #(.NUM_BARS(NUM_BARS)) u_merge (
    .cur    (cfg_q),
    .wmask  (wmask),
    .en     (wr_fire),
    .addr   (addr),
    .len    (len),
    .wdata  (wdata),
    .nxt    (cfg_nxt),
    .bar_chg(bar_chg)
  );

  cfgs_rmux u_rmux (
    .img (cfg_q),
    .sel (sel),
    .addr(addr),
    .len (len),
    .dout(rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= rst_img;
      rdata <= '0;
      remap <= 1'b0;
    end else begin
      if (wr_fire) cfg_q <= cfg_nxt;
      if (rd)      rdata <= rd_val;
      remap <= wr_fire && bar_chg;
    end
  end
endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk
  import cfgs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        rd,
  input logic        wr_fire,
  input logic [7:0]  addr,
  input logic [2:0]  len,
  input logic [1:0]  wlow,
  input logic [31:0] rdata,
  input logic        remap,
  input cfg_img_t    img
);
  assert_remap_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    remap |-> $past(wr_fire));

  assert_enable_flip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && addr == 8'h04 && wlow != img[4][1:0]) |=> remap);

  assert_nowrite_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(img));

  assert_ident_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(img[3:0]));

  assert_miss_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !sel && len == 3'd1) |=> rdata == 32'h0000_00FF);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

bind fn_cfg_regfile cfgs_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sel    (sel),
  .rd     (rd),
  .wr_fire(wr_fire),
  .addr   (addr),
  .len    (len),
  .wlow   (wdata[1:0]),
  .rdata  (rdata),
  .remap  (remap),
  .img    (cfg_q)
);

// File: tb/fn_cfg_regfile_tb.sv
`timescale 1ns/1ps
module fn_cfg_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a = 1'b0, sel_b = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [2:0]  len = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        remap_a, remap_b;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  use_b = 0;
  bit  present = 1;
  logic [7:0] um [256];

  int          lg [7] = '{5, 12, 33, 0, 0, 8, 14};
  logic [3:0]  ty [7] = '{4'h1, 4'h0, 4'hC, 4'h0, 4'h0, 4'h8, 4'h0};

  always #2 clk = ~clk;

  fn_cfg_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel_a), .wr(wr), .rd(rd), .addr(addr),
    .len(len), .wdata(wdata), .rdata(rdata_a), .remap(remap_a));

  fn_cfg_regfile #(.HDR_TYPE(8'h01)) u_brg (
    .clk(clk), .rst_n(rst_n), .sel(sel_b), .wr(wr), .rd(rd), .addr(addr),
    .len(len), .wdata(wdata), .rdata(rdata_b), .remap(remap_b));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d,
                       output logic pulse);
    addr = a; len = l; wdata = d; wr = 1'b1;
    sel_a = present && !use_b; sel_b = present && use_b;
    @(posedge clk); @(negedge clk);
    pulse = use_b ? remap_b : remap_a;
    wr = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
    if (present && !use_b)
      for (int k = 0; k < ((l == 3'd1) ? 1 : (l == 3'd2) ? 2 : 4); k++)
        if (int'(a) + k >= 64 && int'(a) + k <= 255) um[int'(a) + k] = d[8*k +: 8];
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [2:0] l, output logic [31:0] v);
    addr = a; len = l; rd = 1'b1;
    sel_a = present && !use_b; sel_b = present && use_b;
    @(posedge clk); @(negedge clk);
    v = use_b ? rdata_b : rdata_a;
    rd = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 256; i++) um[i] = 8'h00;
  endtask

  function automatic logic [31:0] bar_exp(input int j);
    logic [63:0] sz, neg;
    if (lg[j] != 0) begin
      sz  = 64'd1 << lg[j];
      neg = 64'd0 - sz;
      return (neg[31:0] & (ty[j][0] ? 32'hFFFF_FFFC : 32'hFFFF_FFF0)) | {28'd0, ty[j]};
    end
    if (j > 0 && lg[j-1] != 0 && !ty[j-1][0] && ty[j-1][2:1] == 2'b10) begin
      sz  = 64'd1 << lg[j-1];
      neg = 64'd0 - sz;
      return neg[63:32];
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] rom_exp();
    logic [63:0] neg;
    neg = 64'd0 - (64'd1 << lg[6]);
    return neg[31:0] | 32'h1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic        p;
    logic [31:0] e;
    @(negedge clk);
    do_reset();

    // R1: reset image
    do_rd(8'h00, 3'd4, v); chk("R1 id", v, 32'h5A17_1BE5);
    do_rd(8'h04, 3'd4, v); chk("R1 cmd", v, 32'h0);
    do_rd(8'h08, 3'd4, v); chk("R1 class", v, 32'h0200_0001);
    do_rd(8'h0C, 3'd4, v); chk("R1 hdr dword", v, 32'h0080_0000);
    for (int j = 0; j < 6; j++) begin
      do_rd(8'(16 + 4*j), 3'd4, v);
      chk($sformatf("R1 bar%0d type", j), v, (lg[j] != 0) ? {28'd0, ty[j]} : 32'h0);
    end

    // R5 R6 R7: sizing sweep
    for (int j = 0; j < 6; j++) begin
      do_wr(8'(16 + 4*j), 3'd4, 32'hFFFF_FFFF, p);
      do_rd(8'(16 + 4*j), 3'd4, v);
      chk($sformatf("R5 R6 size bar%0d", j), v, bar_exp(j));
    end
    do_wr(8'h30, 3'd4, 32'hFFFF_FFFF, p);
    do_rd(8'h30, 3'd4, v); chk("R7 rom std", v, rom_exp());
    use_b = 1;
    do_wr(8'h38, 3'd4, 32'hFFFF_FFFF, p);
    do_rd(8'h38, 3'd4, v); chk("R7 rom bridge", v, rom_exp());
    do_wr(8'h30, 3'd4, 32'hFFFF_FFFF, p);
    do_rd(8'h30, 3'd4, v); chk("R7 bridge 0x30 inert", v, 32'h0);
    use_b = 0;
    do_wr(8'h10, 3'd4, 32'h0000_0000, p);
    do_rd(8'h10, 3'd4, v); chk("R5 io type kept", v, 32'h1);

    // R3: header masks
    do_wr(8'h00, 3'd4, 32'hFFFF_FFFF, p);
    do_rd(8'h00, 3'd4, v); chk("R3 id ro", v, 32'h5A17_1BE5);
    do_wr(8'h04, 3'd4, 32'hFFFF_FFFF, p);
    do_rd(8'h04, 3'd4, v); chk("R3 cmd bits", v, 32'h0000_0007);
    do_wr(8'h0C, 3'd4, 32'hFFFF_FFFF, p);
    do_rd(8'h0C, 3'd4, v); chk("R3 cls only", v, 32'h0080_00FF);
    do_wr(8'h3C, 3'd2, 32'h0000_1234, p);
    do_rd(8'h3C, 3'd4, v); chk("R3 R2 int line", v, 32'h0000_0034);
    do_rd(8'h3C, 3'd1, v); chk("R2 R8 byte read", v, 32'h0000_0034);

    // R4 R2 R8: user area sweep
    for (int a = 64; a < 256; a += 4)
      do_wr(8'(a), 3'd4, (32'h0101_0101 * a) ^ 32'h5A3C_96F0, p);
    for (int a = 64; a < 256; a++) begin
      do_rd(8'(a), 3'd1, v);
      chk($sformatf("R4 byte %0h", a), v, {24'd0, um[a]});
    end
    do_wr(8'h41, 3'd2, 32'hCAFE_BEEF, p);
    do_rd(8'h40, 3'd4, v);
    chk("R2 word lanes", v, {um[67], 8'hBE, 8'hEF, um[64]});
    do_rd(8'h41, 3'd2, v); chk("R8 word read", v, 32'h0000_BEEF);

    // R2 R8: end-of-space truncation
    do_wr(8'hFE, 3'd4, 32'h1122_3344, p);
    do_rd(8'hFD, 3'd4, v); chk("R2 R8 truncate", v, {8'h00, 8'h33, 8'h44, um[253]});
    do_rd(8'h00, 3'd4, v); chk("R2 no wrap", v, 32'h5A17_1BE5);

    // R9 R10: missing function
    present = 0;
    do_rd(8'h40, 3'd1, v); chk("R9 len1", v, 32'h0000_00FF);
    do_rd(8'h40, 3'd2, v); chk("R9 len2", v, 32'h0000_FFFF);
    do_rd(8'h40, 3'd4, v); chk("R9 len4", v, 32'hFFFF_FFFF);
    do_wr(8'h80, 3'd4, 32'h0BAD_F00D, p);
    chk("R10 no remap", {31'd0, p}, 32'h0);
    present = 1;
    do_rd(8'h80, 3'd4, v);
    chk("R10 unchanged", v, {um[131], um[130], um[129], um[128]});

    // R1: reset restore
    do_wr(8'h14, 3'd4, 32'hABCD_E000, p);
    do_reset();
    do_rd(8'h04, 3'd4, v); chk("R1 cmd restore", v, 32'h0);
    do_rd(8'h0C, 3'd4, v); chk("R1 cls restore", v, 32'h0080_0000);
    do_rd(8'h3C, 3'd4, v); chk("R1 intl restore", v, 32'h0);
    do_rd(8'h14, 3'd4, v); chk("R1 bar1 restore", v, 32'h0);
    do_rd(8'h18, 3'd4, v); chk("R1 bar2 restore", v, 32'h0000_000C);

    // R11: remap pulse
    do_wr(8'h14, 3'd4, 32'h1234_5000, p); chk("R11 bar change", {31'd0, p}, 32'h1);
    @(negedge clk); chk("R11 single cycle", {31'd0, remap_a}, 32'h0);
    do_wr(8'h14, 3'd4, 32'h1234_5000, p); chk("R11 same value", {31'd0, p}, 32'h0);
    do_wr(8'h10, 3'd1, 32'h0000_0000, p); chk("R11 masked bar", {31'd0, p}, 32'h0);
    do_wr(8'h04, 3'd1, 32'h0000_0004, p); chk("R11 master only", {31'd0, p}, 32'h0);
    do_wr(8'h04, 3'd1, 32'h0000_0005, p); chk("R11 io toggle", {31'd0, p}, 32'h1);
    do_wr(8'h04, 3'd1, 32'h0000_0007, p); chk("R11 mem toggle", {31'd0, p}, 32'h1);
    do_wr(8'h04, 3'd1, 32'h0000_0007, p); chk("R11 cmd same", {31'd0, p}, 32'h0);
    do_wr(8'h40, 3'd4, 32'h7777_7777, p); chk("R11 user area", {31'd0, p}, 32'h0);
    do_wr(8'h1C, 3'd4, 32'h0000_0002, p); chk("R11 bar upper half", {31'd0, p}, 32'h1);
    e = 32'h0; do_rd(8'h1C, 3'd4, v); chk("R6 upper value", v, e | 32'h2);

    finish_run();
  end
endmodule